// File: doc/BRIEF.md
# Byte-Lane Arithmetic and Logic Unit

This block is the execution stage of a small 32-bit integer core. Each cycle it receives two 32-bit operands, an 8-bit lane immediate, a 4-bit shift count and a 5-bit operation code. It returns a combinational 32-bit result and a write-enable for that result. A four-bit condition register holds zero, carry, negative and overflow, and it is updated on the clock edge that ends an issued operation.

The operations are add and subtract, each with a plain and a with-carry form, bitwise logic, logical left and arithmetic right shifts, rotates, two's-complement negate, and a flags-only compare. Four lane-insert operations also write an 8-bit immediate into one byte lane of the first operand. Lane 0 clears everything above the immediate. Lanes 1 to 3 keep the bytes below the lane and clear the bytes above it. Four successive inserts, from lane 0 to lane 3, therefore build any 32-bit constant in one register. Register write-back, memory access and branch decisions belong to neighbouring blocks.

Top module: `lane_alu`

## Requirements
- R1: Code 00000 gives A+B and code 00001 gives A+B+C, where C is the current carry flag. The carry flag takes the carry out of bit 31.
- R2: Code 00010 gives A-B and code 00011 gives A-B-C. The carry flag takes the borrow: it is 1 when the true difference is negative.
- R3: For add, subtract, compare and negate, the overflow flag is 1 exactly when both operands of the underlying addition have the same sign and the sign of the 32-bit result differs from it.
- R4: Every flag-updating operation sets zero when the 32-bit result is all zeros and sets negative to result bit 31. The flag-updating operations are arithmetic, logic, shift, rotate, compare and negate.
- R5: Codes 00100, 00101, 00110 and 00111 give A and B, A or B, A xor B, and the complement of A. Carry and overflow keep their values.
- R6: Code 01000 returns the immediate in bits 7..0, with bits 31..8 equal to zero.
- R7: Codes 01001, 01010 and 01011 write the immediate into lane 1 (bits 15..8), lane 2 (bits 23..16) or lane 3 (bits 31..24). Bytes below the lane come from A and bytes above it are zero. Lane-insert operations leave all flags unchanged.
- R8: Code 01110 shifts A left by the 4-bit count, filling with zeros. Code 01111 shifts A right by the count, filling with copies of bit 31. Carry and overflow keep their values.
- R9: Code 01100 rotates A left and code 01101 rotates A right by the 4-bit count. A count of 0 returns A unchanged.
- R10: Code 10000 computes A-B and updates all four flags as subtract does. The result write-enable stays low.
- R11: Code 10001 returns 0-A and updates all four flags as a subtract from zero does.
- R12: Flags change only on an edge where the issue enable is high. The write-enable is high only for an issued code that writes a result. Any code not listed above returns zero, keeps the write-enable low and leaves the flags unchanged.
- R13: While reset is asserted, all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_en | input | 1 | An operation is issued this cycle |
| op_code | input | 5 | Operation selector |
| opnd_a | input | 32 | First operand, and the prior register value for lane inserts |
| opnd_b | input | 32 | Second operand |
| lane_imm | input | 8 | Byte immediate for lane inserts |
| shamt | input | 4 | Shift or rotate count |
| res | output | 32 | Combinational result |
| res_wr | output | 1 | Result write-enable |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench chains operations so that with-carry add and subtract consume the carry left by the step before. A design that ignored the carry-in, or that put the raw adder carry in place of the borrow, would be off by one or report the wrong carry. Signed overflow is driven at both ends of the number range, including negate of the most negative value. A design with a wrong sign rule would miss those cases. Logic operations and shifts run while carry and overflow are set, which exposes a design that clears them. The bench builds a constant one lane at a time and also inserts into lane 1 over an all-ones word, so it catches a design that keeps or clears the wrong bytes. It also issues a rotate by zero, an arithmetic shift of a negative word, compares that must not write, and operations with the issue enable low, which catch a design that wraps the count wrongly, fills the wrong sign bits, writes on a compare, or updates state when not issued.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'b00000,
    OP_ADC = 5'b00001,
    OP_SUB = 5'b00010,
    OP_SBC = 5'b00011,
    OP_AND = 5'b00100,
    OP_OR  = 5'b00101,
    OP_XOR = 5'b00110,
    OP_NOT = 5'b00111,
    OP_LD0 = 5'b01000,
    OP_LD1 = 5'b01001,
    OP_LD2 = 5'b01010,
    OP_LD3 = 5'b01011,
    OP_ROL = 5'b01100,
    OP_ROR = 5'b01101,
    OP_LSL = 5'b01110,
    OP_ASR = 5'b01111,
    OP_CMP = 5'b10000,
    OP_NEG = 5'b10001
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } alu_flags_t;

  // Shift unit mode, taken from the low two code bits of the shift group
  localparam logic [1:0] SH_ROL = 2'b00;
  localparam logic [1:0] SH_ROR = 2'b01;
  localparam logic [1:0] SH_LSL = 2'b10;
  localparam logic [1:0] SH_ASR = 2'b11;

endpackage

// File: rtl/lane_alu_addsub.sv
module lane_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] add_a,
  input  logic [W-1:0] add_b,
  input  logic         sub_mode,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cy_out,
  output logic         ovf
);

  logic [W-1:0] b_eff;
  logic         raw_co;

  always_comb begin
    b_eff = sub_mode ? ~add_b : add_b;
    {raw_co, sum} = {1'b0, add_a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    // In subtract mode the carry flag reports a borrow
    cy_out = sub_mode ? ~raw_co : raw_co;
    ovf    = (add_a[W-1] == b_eff[W-1]) && (sum[W-1] != add_a[W-1]);
  end

endmodule

// File: rtl/lane_alu_shift.sv
module lane_alu_shift #(
  parameter int W  = 32,
  parameter int SW = 4
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic [1:0]    mode,
  output logic [W-1:0]  shifted
);
  import lane_alu_pkg::*;

  logic [2*W-1:0] dbl;
  logic [2*W-1:0] dbl_l;
  logic [2*W-1:0] dbl_r;

  always_comb begin
    dbl   = {val, val};
    dbl_l = dbl << amt;
    dbl_r = dbl >> amt;
    unique case (mode)
      SH_ROL:  shifted = dbl_l[2*W-1:W];
      SH_ROR:  shifted = dbl_r[W-1:0];
      SH_LSL:  shifted = val << amt;
      default: shifted = W'($signed(val) >>> amt);
    endcase
  end

endmodule

// File: rtl/lane_alu_lane.sv
module lane_alu_lane #(
  parameter int W  = 32,
  parameter int LW = 8,
  localparam int NL   = W / LW,
  localparam int SELW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic [W-1:0]    base,
  input  logic [LW-1:0]   imm,
  input  logic [SELW-1:0] sel,
  output logic [W-1:0]    merged
);

  for (genvar k = 0; k < NL; k++) begin : g_lane
    always_comb begin
      if (int'(sel) == k)
        merged[k*LW +: LW] = imm;
      else if (k < int'(sel))
        merged[k*LW +: LW] = base[k*LW +: LW];
      else
        merged[k*LW +: LW] = '0;
    end
  end

endmodule

// File: rtl/lane_alu_flagreg.sv
module lane_alu_flagreg (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_zn,
  input  logic                      upd_cv,
  input  lane_alu_pkg::alu_flags_t  cand,
  output lane_alu_pkg::alu_flags_t  cur
);
  import lane_alu_pkg::*;

  alu_flags_t nxt;

  always_comb begin
    nxt = cur;
    if (upd_zn) begin
      nxt.z = cand.z;
      nxt.n = cand.n;
    end
    if (upd_cv) begin
      nxt.c = cand.c;
      nxt.v = cand.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu #(
  parameter int DATA_W = 32,
  parameter int SH_W   = 4,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int LSELW = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [LANE_W-1:0] lane_imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] res,
  output logic              res_wr,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_n,
  output logic              flag_v
);
  import lane_alu_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  alu_flags_t flags_q;
  alu_flags_t flags_cand;

  // Adder operand selection
  logic [DATA_W-1:0] as_a, as_b, as_sum;
  logic              as_sub, as_cin, as_cy, as_ovf;

  always_comb begin
    as_a   = opnd_a;
    as_b   = opnd_b;
    as_sub = 1'b0;
    as_cin = 1'b0;
    unique case (op_code)
      OP_ADC: as_cin = flags_q.c;
      OP_SUB, OP_CMP: begin
        as_sub = 1'b1;
        as_cin = 1'b1;
      end
      OP_SBC: begin
        as_sub = 1'b1;
        as_cin = ~flags_q.c;
      end
      OP_NEG: begin
        as_a   = '0;
        as_b   = opnd_a;
        as_sub = 1'b1;
        as_cin = 1'b1;
      end
      default: ;
    endcase
  end

  lane_alu_addsub #(.W(DATA_W)) u_addsub (
    .add_a   (as_a),
    .add_b   (as_b),
    .sub_mode(as_sub),
    .cin     (as_cin),
    .sum     (as_sum),
    .cy_out  (as_cy),
    .ovf     (as_ovf)
  );

  logic [DATA_W-1:0] sh_out;
  lane_alu_shift #(.W(DATA_W), .SW(SH_W)) u_shift (
    .val    (opnd_a),
    .amt    (shamt),
    .mode   (op_code[1:0]),
    .shifted(sh_out)
  );

  logic [DATA_W-1:0] lane_out;
  lane_alu_lane #(.W(DATA_W), .LW(LANE_W)) u_lane (
    .base  (opnd_a),
    .imm   (lane_imm),
    .sel   (op_code[LSELW-1:0]),
    .merged(lane_out)
  );

  // Result mux and operation classes
  logic cls_arith, cls_zn_only, cls_write;

  always_comb begin
    res         = '0;
    cls_arith   = 1'b0;
    cls_zn_only = 1'b0;
    cls_write   = 1'b1;
    unique case (op_code)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res       = as_sum;
        cls_arith = 1'b1;
      end
      OP_CMP: begin
        res       = as_sum;
        cls_arith = 1'b1;
        cls_write = 1'b0;
      end
      OP_AND: begin res = opnd_a & opnd_b; cls_zn_only = 1'b1; end
      OP_OR:  begin res = opnd_a | opnd_b; cls_zn_only = 1'b1; end
      OP_XOR: begin res = opnd_a ^ opnd_b; cls_zn_only = 1'b1; end
      OP_NOT: begin res = ~opnd_a;         cls_zn_only = 1'b1; end
      OP_ROL, OP_ROR, OP_LSL, OP_ASR: begin
        res         = sh_out;
        cls_zn_only = 1'b1;
      end
      OP_LD0, OP_LD1, OP_LD2, OP_LD3: res = lane_out;
      default: cls_write = 1'b0;
    endcase
  end

  assign res_wr = issue_en & cls_write;

  always_comb begin
    flags_cand.z = (res == '0);
    flags_cand.n = res[DATA_W-1];
    flags_cand.c = as_cy;
    flags_cand.v = as_ovf;
  end

  lane_alu_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .upd_zn(issue_en & (cls_arith | cls_zn_only)),
    .upd_cv(issue_en & cls_arith),
    .cand  (flags_cand),
    .cur   (flags_q)
  );

  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_n = flags_q.n;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int W  = 32,
  parameter int LW = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         issue_en,
  input logic [4:0]   op_code,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] res,
  input logic         res_wr,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_n,
  input logic         flag_v
);

  logic zn_op, logic_op;
  always_comb begin
    logic_op = (op_code[4:2] == 3'b001);
    zn_op    = (op_code[4:3] == 2'b00) || (op_code[4:2] == 3'b011) ||
               (op_code == 5'b10000) || (op_code == 5'b10001);
  end

  // R10
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code == 5'b10000) |-> !res_wr);

  // R5
  logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_en && logic_op) |=> (flag_c == $past(flag_c)) && (flag_v == $past(flag_v)));

  // R12
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_en |=> $stable({flag_z, flag_c, flag_n, flag_v}));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_en && zn_op) |=> (flag_z == ($past(res) == '0)) && (flag_n == $past(res[W-1])));

  // R6
  lane0_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code == 5'b01000) |-> (res[W-1:LW] == '0));

  // R7
  lane1_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code == 5'b01001) |-> (res[LW-1:0] == opnd_a[LW-1:0]));

endmodule

bind lane_alu lane_alu_chk #(.W(DATA_W), .LW(LANE_W)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .issue_en  (issue_en),
  .op_code   (op_code),
  .opnd_a    (opnd_a),
  .res       (res),
  .res_wr    (res_wr),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_n    (flag_n),
  .flag_v    (flag_v)
);

// File: tb/lane_alu_tb.sv
module lane_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 28;
  localparam int VW = 118;

  // {op, a, b, imm, sh, exp_res, exp_wr, exp flags z c n v}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {5'b00000, 32'hFFFFFFFF, 32'h00000001, 8'h00, 4'h0, 32'h00000000, 1'b1, 4'b1100}, // R1 R4
    {5'b00001, 32'h00000005, 32'h00000006, 8'h00, 4'h0, 32'h0000000C, 1'b1, 4'b0000}, // R1 adc
    {5'b00000, 32'h7FFFFFFF, 32'h00000001, 8'h00, 4'h0, 32'h80000000, 1'b1, 4'b0011}, // R3
    {5'b00010, 32'h00000003, 32'h00000005, 8'h00, 4'h0, 32'hFFFFFFFE, 1'b1, 4'b0110}, // R2
    {5'b00011, 32'h0000000A, 32'h00000003, 8'h00, 4'h0, 32'h00000006, 1'b1, 4'b0000}, // R2 sbc
    {5'b00010, 32'h80000000, 32'h00000001, 8'h00, 4'h0, 32'h7FFFFFFF, 1'b1, 4'b0001}, // R3
    {5'b00100, 32'hF0F0F0F0, 32'h0F0F0F0F, 8'h00, 4'h0, 32'h00000000, 1'b1, 4'b1001}, // R5
    {5'b00101, 32'h80000000, 32'h00000001, 8'h00, 4'h0, 32'h80000001, 1'b1, 4'b0011}, // R5
    {5'b00110, 32'hFFFF0000, 32'hFF00FF00, 8'h00, 4'h0, 32'h00FFFF00, 1'b1, 4'b0001}, // R5
    {5'b00111, 32'h0000FFFF, 32'h00000000, 8'h00, 4'h0, 32'hFFFF0000, 1'b1, 4'b0011}, // R5
    {5'b00010, 32'h00000000, 32'h00000001, 8'h00, 4'h0, 32'hFFFFFFFF, 1'b1, 4'b0110}, // R2
    {5'b01110, 32'h80000001, 32'h00000000, 8'h00, 4'h4, 32'h00000010, 1'b1, 4'b0100}, // R8
    {5'b01111, 32'h80000000, 32'h00000000, 8'h00, 4'hF, 32'hFFFF0000, 1'b1, 4'b0110}, // R8
    {5'b01100, 32'h80000001, 32'h00000000, 8'h00, 4'h1, 32'h00000003, 1'b1, 4'b0100}, // R9
    {5'b01101, 32'h00000003, 32'h00000000, 8'h00, 4'h4, 32'h30000000, 1'b1, 4'b0100}, // R9
    {5'b01101, 32'h12345678, 32'h00000000, 8'h00, 4'h0, 32'h12345678, 1'b1, 4'b0100}, // R9
    {5'b01000, 32'hFFFFFFFF, 32'h00000000, 8'hAB, 4'h0, 32'h000000AB, 1'b1, 4'b0100}, // R6
    {5'b01001, 32'h000000AB, 32'h00000000, 8'hCD, 4'h0, 32'h0000CDAB, 1'b1, 4'b0100}, // R7
    {5'b01010, 32'h0000CDAB, 32'h00000000, 8'hEF, 4'h0, 32'h00EFCDAB, 1'b1, 4'b0100}, // R7
    {5'b01011, 32'h00EFCDAB, 32'h00000000, 8'h12, 4'h0, 32'h12EFCDAB, 1'b1, 4'b0100}, // R7
    {5'b01001, 32'hFFFFFFFF, 32'h00000000, 8'h00, 4'h0, 32'h000000FF, 1'b1, 4'b0100}, // R7
    {5'b10000, 32'h00000005, 32'h00000005, 8'h00, 4'h0, 32'h00000000, 1'b0, 4'b1000}, // R10
    {5'b10000, 32'h00000002, 32'h00000007, 8'h00, 4'h0, 32'hFFFFFFFB, 1'b0, 4'b0110}, // R10
    {5'b10001, 32'h00000001, 32'h00000000, 8'h00, 4'h0, 32'hFFFFFFFF, 1'b1, 4'b0110}, // R11
    {5'b10001, 32'h80000000, 32'h00000000, 8'h00, 4'h0, 32'h80000000, 1'b1, 4'b0111}, // R11 R3
    {5'b10001, 32'h00000000, 32'h00000000, 8'h00, 4'h0, 32'h00000000, 1'b1, 4'b1000}, // R11
    {5'b11111, 32'hDEADBEEF, 32'h12345678, 8'h55, 4'h3, 32'h00000000, 1'b0, 4'b1000}, // R12
    {5'b01110, 32'hFFFFFFFF, 32'h00000000, 8'h00, 4'hF, 32'hFFFF8000, 1'b1, 4'b0010}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_en;
  logic [4:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic [7:0]  lane_imm;
  logic [3:0]  shamt;
  logic [31:0] res;
  logic        res_wr;
  logic        flag_z, flag_c, flag_n, flag_v;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_alu dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_en(issue_en),
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .lane_imm(lane_imm),
    .shamt   (shamt),
    .res     (res),
    .res_wr  (res_wr),
    .flag_z  (flag_z),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_v  (flag_v)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flags4();
    return {28'h0, flag_z, flag_c, flag_n, flag_v};
  endfunction

  task automatic drive(input logic en, input logic [4:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] im, input logic [3:0] sh);
    issue_en = en; op_code = op; opnd_a = a; opnd_b = b; lane_imm = im; shamt = sh;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 5'b00000, '0, '0, '0, '0);
    repeat (2) @(negedge clk);
    // R13: flags zero under reset
    check("R13 reset flags", flags4(), 32'h0);
    check("R12 no write when idle", {31'h0, res_wr}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Table walk: result checked before the edge, flags after it
    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      drive(1'b1, v[117:113], v[112:81], v[80:49], v[48:41], v[40:37]);
      #1;
      check($sformatf("vec %0d result (R1-R11 table)", i), res, v[36:5]);
      check($sformatf("vec %0d write-enable R12", i), {31'h0, res_wr}, {31'h0, v[4]});
      @(posedge clk);
      #1;
      check($sformatf("vec %0d flags R4", i), flags4(), {28'h0, v[3:0]});
      @(negedge clk);
    end

    // R12: issue enable low leaves flags and write-enable quiet
    drive(1'b1, 5'b00000, 32'hFFFFFFFF, 32'h1, 8'h0, 4'h0);
    @(posedge clk); #1;
    check("R1 setup flags", flags4(), 32'hC);
    @(negedge clk);
    drive(1'b0, 5'b00010, 32'h0, 32'h1, 8'h0, 4'h0);
    #1;
    check("R12 idle write-enable", {31'h0, res_wr}, 32'h0);
    @(posedge clk); #1;
    check("R12 idle flags held", flags4(), 32'hC);
    @(negedge clk);

    // R13: reset in mid-run clears the flags at once
    rst_n = 1'b0;
    #1;
    check("R13 mid-run reset", flags4(), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule